// File: doc/BRIEF.md
# Reset Sequencer and Phase Generator

This block produces the reset and clock-phase signals that a coprocessor hands to the devices behind it. An active-low external reset enters asynchronously. It is resynchronised and driven out as an active-low downstream reset. That output drops at once when the external reset asserts, and it releases only on a clock edge. Alongside it runs an active-low phase signal. The phase signal is held low whenever the downstream reset is asserted, and otherwise toggles every clock, so it runs at half the clock rate.

Software reaches the block through a small configuration register. Bit 0 is a self-clearing soft-reset bit and bits 7:1 hold a mode field. Writing a 1 to bit 0 starts an internal reset. That reset holds the downstream reset low for `HOLD_CYCLES` clocks (default 64, at least 32). When it ends, the mode field returns to its default and bit 0 clears. Software can therefore wait 32 cycles and then poll bit 0 until it reads 0.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_ni` is low, `dn_rst_no` is low without waiting for a clock edge. After `rst_ni` rises, `dn_rst_no` rises on the second rising clock edge (with `SYNC_STAGES` = 2).
- R2: `phase_no` is low in every cycle in which `dn_rst_no` is low.
- R3: On the first clock edge after `dn_rst_no` rises, `phase_no` rises. From then on it inverts on every edge while `dn_rst_no` stays high.
- R4: `cfg_rdata_o` reads as {mode field [7:1], soft-reset bit [0]}. When the block is idle, a write with bit 0 = 0 loads bits 7:1 into the mode field, visible after the write edge. Without `cfg_we_i`, the register does not change.
- R5: When the block is idle, a write with bit 0 = 1 sets the soft-reset bit at the write edge. The mode bits of that write are ignored, so the field keeps its value.
- R6: Once set, the soft-reset bit reads 1 and `dn_rst_no` stays low for exactly `HOLD_CYCLES` cycles. The bit still reads 1 when polled 32 cycles after the write. After that, both release on the same edge.
- R7: When a soft reset completes, the mode field holds its default value 7'h15, so `cfg_rdata_o` reads 8'h2A. The same value is loaded by `rst_ni`.
- R8: Any write while a soft reset is running is ignored. It neither changes the mode field nor lengthens the hold.
- R9: Asserting `rst_ni` during a soft reset aborts it at once. The register returns to 8'h2A and the downstream reset follows the timing of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | External active-low reset, asynchronous |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration write data: bit 0 soft reset, bits 7:1 mode field |
| cfg_rdata_o | output | 8 | Configuration register read value |
| dn_rst_no | output | 1 | Downstream active-low reset |
| phase_no | output | 1 | Active-low half-rate phase signal |

## Verification
The hardest situations to reach are the ones inside a running soft reset. These are the edge where the hold ends and the phase restarts, a field write or a second soft-reset write that lands mid-hold, and an external reset that cuts the hold short. The stimulus starts a soft reset and counts edges from the write. It injects a field write and a repeated soft-reset write at chosen offsets, and polls the bit at offset 32. It then samples at exactly the edge where the hold should end. A second soft reset is interrupted by dropping `rst_ni` between clock edges. This shows the asynchronous abort and the resynchronised release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int CFG_W    = 8;
  localparam int SRST_BIT = 0;
  localparam int FIELD_W  = CFG_W - 1;
  typedef logic [FIELD_W-1:0] field_t;
  localparam field_t FIELD_DEF = 7'h15;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic rst_no,
  output logic rst_next_o
);
  logic [STAGES-1:0] q;

  // last stage also absorbs the soft-reset hold
  assign rst_next_o = q[STAGES-2] & ~hold_i;
  assign rst_no     = q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      q[0] <= 1'b1;
      for (int i = 1; i < STAGES-1; i++) q[i] <= q[i-1];
      q[STAGES-1] <= rst_next_o;
    end
  end
endmodule

// File: rtl/rstseq_soft.sv
module rstseq_soft
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYCLES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic             busy_next_o
);
  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  field_t           field_q;
  logic             start, last;

  assign start       = we_i & wdata_i[SRST_BIT] & ~busy_q;
  assign last        = busy_q & (cnt_q == '0);
  assign busy_next_o = start | (busy_q & ~last);
  assign rdata_o     = {field_q, busy_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      field_q <= FIELD_DEF;
    end else if (busy_q) begin
      if (last) begin
        busy_q  <= 1'b0;
        field_q <= FIELD_DEF;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(HOLD_CYCLES - 1);
    end else if (we_i) begin
      field_q <= wdata_i[CFG_W-1:1];
    end
  end
endmodule

// File: rtl/rstseq_phase.sv
module rstseq_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_cur_i,
  input  logic rst_next_i,
  output logic phase_o
);
  logic phase_q;
  assign phase_o = phase_q;

  // forced low on the edge the reset asserts and while it stays asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= (rst_cur_i & rst_next_i) ? ~phase_q : 1'b0;
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             dn_rst_no,
  output logic             phase_no
);
  logic soft_next;
  logic rst_next;

  rstseq_soft #(.HOLD_CYCLES(HOLD_CYCLES)) u_soft (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .busy_next_o (soft_next)
  );

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (soft_next),
    .rst_no     (dn_rst_no),
    .rst_next_o (rst_next)
  );

  rstseq_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_cur_i  (dn_rst_no),
    .rst_next_i (rst_next),
    .phase_o    (phase_no)
  );
endmodule

// File: rtl/rstseq_top_chk.sv
module rstseq_top_chk
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYCLES = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             wr_srst_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             dn_rst_no,
  input logic             phase_no
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             busy_cnt <= '0;
    else if (cfg_rdata_o[0]) busy_cnt <= busy_cnt + 1;
    else                     busy_cnt <= '0;
  end

  p_phase_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dn_rst_no |-> !phase_no);

  p_phase_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_rst_no && $past(dn_rst_no)) |-> (phase_no != $past(phase_no)));

  p_srst_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_srst_i && !cfg_rdata_o[0]) |=> cfg_rdata_o[0]);

  p_srst_holds_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[0] |-> !dn_rst_no);

  p_hold_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_rdata_o[0]) |-> (busy_cnt == 32'(HOLD_CYCLES)));

  p_default_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_rdata_o[0]) |-> (cfg_rdata_o[CFG_W-1:1] == FIELD_DEF));

  p_field_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[0] && $past(cfg_rdata_o[0])) |-> $stable(cfg_rdata_o[CFG_W-1:1]));
endmodule

bind rstseq_top rstseq_top_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .wr_srst_i   (cfg_wdata_i[0]),
  .cfg_rdata_o (cfg_rdata_o),
  .dn_rst_no   (dn_rst_no),
  .phase_no    (phase_no)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
  localparam int HOLD = 64;
  localparam int NVEC = 6;
  // {we, wdata, expected rdata}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'h00},
    {1'b1, 8'hFE, 8'hFE},
    {1'b1, 8'h54, 8'h54},
    {1'b0, 8'h33, 8'h54},
    {1'b1, 8'hAA, 8'hAA},
    {1'b1, 8'h02, 8'h02}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic [7:0] cfg_rdata_o;
  logic       dn_rst_no, phase_no;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstseq_top #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) u_rstseq_top (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .dn_rst_no   (dn_rst_no),
    .phase_no    (phase_no)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) step();
    chk("R1 reset dn", {7'd0, dn_rst_no}, 8'd0);
    chk("R2 reset phase", {7'd0, phase_no}, 8'd0);
    chk("R7 reset cfg", cfg_rdata_o, 8'h2A);
    rst_ni = 1'b1;
    step();
    chk("R1 dn after edge 1", {7'd0, dn_rst_no}, 8'd0);
    step();
    chk("R1 dn after edge 2", {7'd0, dn_rst_no}, 8'd1);
    chk("R2 phase at release", {7'd0, phase_no}, 8'd0);
    step();
    chk("R3 first phase rise", {7'd0, phase_no}, 8'd1);
    step();
    chk("R3 phase toggle", {7'd0, phase_no}, 8'd0);
    step();
    chk("R3 phase toggle", {7'd0, phase_no}, 8'd1);

    for (int i = 0; i < NVEC; i++) begin
      cfg_we_i    = VEC[i][16];
      cfg_wdata_i = VEC[i][15:8];
      step();
      cfg_we_i = 1'b0;
      chk("R4 field write", cfg_rdata_o, VEC[i][7:0]);
    end

    // soft reset with nonzero field bits, which must be ignored
    cfg_we_i = 1'b1; cfg_wdata_i = 8'hFD;
    step();
    cfg_we_i = 1'b0;
    chk("R5 srst set, field kept", cfg_rdata_o, 8'h03);
    chk("R6 dn low at start", {7'd0, dn_rst_no}, 8'd0);
    chk("R2 phase low in soft reset", {7'd0, phase_no}, 8'd0);
    for (int k = 1; k < HOLD; k++) begin
      if (k == 5)  begin cfg_we_i = 1'b1; cfg_wdata_i = 8'hFE; end
      if (k == 10) begin cfg_we_i = 1'b1; cfg_wdata_i = 8'h01; end
      step();
      cfg_we_i = 1'b0;
      chk("R6 dn held low", {7'd0, dn_rst_no}, 8'd0);
      if (k == 5 || k == 10) chk("R8 write ignored", cfg_rdata_o, 8'h03);
      if (k == 32) chk("R6 poll at 32", cfg_rdata_o, 8'h03);
    end
    step();
    chk("R7 default after soft reset", cfg_rdata_o, 8'h2A);
    chk("R6 dn released", {7'd0, dn_rst_no}, 8'd1);
    chk("R2 phase low at release", {7'd0, phase_no}, 8'd0);
    step();
    chk("R3 phase restarts", {7'd0, phase_no}, 8'd1);
    step();
    chk("R3 phase toggle", {7'd0, phase_no}, 8'd0);

    // external reset aborts a running soft reset
    cfg_we_i = 1'b1; cfg_wdata_i = 8'h41;
    step();
    cfg_we_i = 1'b0;
    repeat (3) step();
    chk("R9 busy before abort", cfg_rdata_o, 8'h2B);
    #3 rst_ni = 1'b0;
    #1;
    chk("R9 async abort cfg", cfg_rdata_o, 8'h2A);
    chk("R1 async dn", {7'd0, dn_rst_no}, 8'd0);
    step();
    rst_ni = 1'b1;
    step();
    chk("R9 dn after edge 1", {7'd0, dn_rst_no}, 8'd0);
    step();
    chk("R9 dn after edge 2", {7'd0, dn_rst_no}, 8'd1);
    chk("R9 cfg idle", cfg_rdata_o, 8'h2A);
    step();
    chk("R3 phase rise after abort", {7'd0, phase_no}, 8'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule